// File: doc/BRIEF.md
# Serial Frame Transmitter with Parity and Line Break

This block turns bytes into asynchronous serial frames on a single output line. The host pushes bytes into a sixteen-entry queue. A serializer takes each byte from the queue and sends one frame: a low start bit, then five to eight data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The line is high between frames. The block does not divide the clock itself. It takes a single-cycle tick that pulses sixteen times per bit period, and every bit lasts sixteen of those ticks.

A set of format inputs selects the frame format:
- the word length;
- one or two stop bits;
- whether a parity bit is sent;
- the parity kind: odd, even, always-one or always-zero.

The serializer samples the format at the moment it takes a byte from the queue. The host should therefore change the format only while the transmitter reports empty. A separate break input forces the line low for as long as it is held, whatever the serializer is doing. Two flags report progress. One says the queue holds no byte. The other says that both the queue and the serializer are empty.

Top module: `serial_tx_top`

## Requirements
- R1: After reset, and whenever the transmitter has been empty for a cycle with break low, `txd` is 1. After reset `hold_empty` and `tx_empty` are both 1.
- R2: A frame begins with one 0 start bit. The data bits follow, least significant bit first. Every bit lasts 16 `baud_tick16` pulses.
- R3: The `fmt_len` code selects the number of data bits: 0 selects 5 bits, 1 selects 6, 2 selects 7 and 3 selects 8. Unused upper data bits are not sent.
- R4: `fmt_stop2` = 0 gives one stop bit of value 1. `fmt_stop2` = 1 gives two stop bits of value 1.
- R5: With `fmt_par_en` = 0, no parity bit is sent, whatever `fmt_par_sel` and `fmt_par_fix` are. The first stop bit follows the last data bit directly.
- R6: With `fmt_par_en` = 1 and `fmt_par_fix` = 0, the parity bit follows the last data bit. With `fmt_par_sel` = 0 the data bits and parity bit together hold an odd number of ones. With `fmt_par_sel` = 1 they hold an even number of ones.
- R7: With `fmt_par_en` = 1 and `fmt_par_fix` = 1, the parity bit is 1 when `fmt_par_sel` = 0 and 0 when `fmt_par_sel` = 1.
- R8: While `line_break` is 1, `txd` is 0 from the next cycle on. It stays 0 until `line_break` is cleared. A break does not change `hold_empty` or `tx_empty`.
- R9: `hold_empty` is 1 exactly when the queue holds no byte. It is already 0 in the cycle in which `wr_en` is high.
- R10: `tx_empty` is 1 only when both the queue and the serializer are empty. It is 0 for the whole of a frame, even after the queue has drained.
- R11: The queue holds 16 bytes. A write while the queue is full is dropped. Accepted bytes are sent in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push `wr_data` into the queue this cycle |
| wr_data | input | 8 | Byte to transmit |
| baud_tick16 | input | 1 | One-cycle pulse, 16 per bit period |
| fmt_len | input | 2 | Word length code (5 to 8 data bits) |
| fmt_stop2 | input | 1 | 1 selects two stop bits |
| fmt_par_en | input | 1 | 1 adds a parity bit |
| fmt_par_sel | input | 1 | Parity kind: odd/even, or mark/space when fixed |
| fmt_par_fix | input | 1 | 1 makes the parity bit a constant |
| line_break | input | 1 | Holds `txd` low while 1 |
| txd | output | 1 | Serial output, idle high |
| hold_empty | output | 1 | Queue holds no byte |
| tx_empty | output | 1 | Queue and serializer both empty |

## Verification
The host write and the serializer's pop from the queue can fall in the same cycle. The bench provokes this by writing eighteen bytes on consecutive cycles into an idle transmitter. The second write lands on the same edge as the pop of the first byte, and the eighteenth write meets a full queue. The scoreboard then has to see exactly seventeen frames, in order, with no extra frame and none lost. That one result shows both that the simultaneous push and pop kept the count exact and that the drop on full happened at the right depth.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [1:0] len;
        logic       stop2;
        logic       par_en;
        logic       par_sel;
        logic       par_fix;
    } tx_fmt_t;

    typedef enum logic [2:0] {
        SER_IDLE,
        SER_START,
        SER_DATA,
        SER_PAR,
        SER_STOP
    } ser_state_e;

    // number of data bits for a length code
    function automatic logic [3:0] data_bits(input logic [1:0] len);
        return 4'd5 + {2'b00, len};
    endfunction

    // keep only the bits that go on the line
    function automatic logic [BYTE_W-1:0] trim_data(input logic [BYTE_W-1:0] d,
                                                    input logic [1:0]        len);
        logic [BYTE_W-1:0] m;
        m = 8'hFF >> (2'd3 - len);
        return d & m;
    endfunction

    function automatic logic parity_of(input logic [BYTE_W-1:0] d, input tx_fmt_t f);
        logic ones_odd;
        ones_odd = ^trim_data(d, f.len);
        if (f.par_fix) begin
            return ~f.par_sel;
        end
        return ones_odd ^ ~f.par_sel;
    endfunction

endpackage

// File: rtl/tx_queue.sv
module tx_queue #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] level
);
    logic [W-1:0]  slots [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          take_in;
    logic          take_out;

    assign take_in  = push && (level != CW'(DEPTH));
    assign take_out = pop && (level != '0);
    assign head     = slots[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (take_in) begin
            slots[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (take_in) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (take_out) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({take_in, take_out})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
    parameter int TICKS = 16,
    localparam int TW   = (TICKS > 1) ? $clog2(TICKS) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic tick,
    output logic bit_done
);
    logic [TW-1:0] phase;

    assign bit_done = tick && (phase == TW'(TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase <= '0;
        end else if (tick) begin
            phase <= (phase == TW'(TICKS - 1)) ? '0 : phase + 1'b1;
        end
    end

endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
    import serial_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  tx_fmt_t           fmt,
    input  logic              have_byte,
    input  logic [BYTE_W-1:0] next_byte,
    input  logic              bit_done,
    output logic              take_byte,
    output logic              line,
    output logic              busy
);
    ser_state_e        state;
    tx_fmt_t           fmt_q;
    logic [BYTE_W-1:0] shreg;
    logic [3:0]        bit_idx;
    logic              par_q;
    logic              stop_idx;

    assign take_byte = (state == SER_IDLE) && have_byte;
    assign busy      = (state != SER_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SER_IDLE;
            fmt_q    <= '0;
            shreg    <= '0;
            bit_idx  <= '0;
            par_q    <= 1'b0;
            stop_idx <= 1'b0;
            line     <= 1'b1;
        end else begin
            case (state)
                SER_IDLE: begin
                    line <= 1'b1;
                    if (have_byte) begin
                        state   <= SER_START;
                        line    <= 1'b0;
                        shreg   <= next_byte;
                        fmt_q   <= fmt;
                        par_q   <= parity_of(next_byte, fmt);
                        bit_idx <= '0;
                    end
                end
                SER_START: begin
                    if (bit_done) begin
                        state <= SER_DATA;
                        line  <= shreg[0];
                    end
                end
                SER_DATA: begin
                    if (bit_done) begin
                        if (bit_idx == data_bits(fmt_q.len) - 4'd1) begin
                            if (fmt_q.par_en) begin
                                state <= SER_PAR;
                                line  <= par_q;
                            end else begin
                                state    <= SER_STOP;
                                line     <= 1'b1;
                                stop_idx <= 1'b0;
                            end
                        end else begin
                            shreg   <= shreg >> 1;
                            line    <= shreg[1];
                            bit_idx <= bit_idx + 4'd1;
                        end
                    end
                end
                SER_PAR: begin
                    if (bit_done) begin
                        state    <= SER_STOP;
                        line     <= 1'b1;
                        stop_idx <= 1'b0;
                    end
                end
                SER_STOP: begin
                    if (bit_done) begin
                        if (fmt_q.stop2 && !stop_idx) begin
                            stop_idx <= 1'b1;
                        end else begin
                            state <= SER_IDLE;
                        end
                    end
                end
                default: state <= SER_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/serial_tx_top.sv
module serial_tx_top
    import serial_tx_pkg::*;
#(
    parameter int QUEUE_DEPTH   = 16,
    parameter int TICKS_PER_BIT = 16,
    localparam int LW           = $clog2(QUEUE_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       baud_tick16,
    input  logic [1:0] fmt_len,
    input  logic       fmt_stop2,
    input  logic       fmt_par_en,
    input  logic       fmt_par_sel,
    input  logic       fmt_par_fix,
    input  logic       line_break,
    output logic       txd,
    output logic       hold_empty,
    output logic       tx_empty
);
    tx_fmt_t           fmt;
    logic [LW-1:0]     q_level;
    logic [BYTE_W-1:0] q_head;
    logic              q_pop;
    logic              q_empty;
    logic              bit_done;
    logic              ser_line;
    logic              ser_busy;
    logic              txd_q;

    assign fmt = '{len: fmt_len, stop2: fmt_stop2, par_en: fmt_par_en,
                   par_sel: fmt_par_sel, par_fix: fmt_par_fix};

    tx_queue #(.DEPTH(QUEUE_DEPTH), .W(BYTE_W)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (q_pop),
        .head      (q_head),
        .level     (q_level)
    );

    assign q_empty = (q_level == '0);

    tx_bit_timer #(.TICKS(TICKS_PER_BIT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .restart  (q_pop),
        .tick     (baud_tick16),
        .bit_done (bit_done)
    );

    tx_serializer u_ser (
        .clk       (clk),
        .rst       (rst),
        .fmt       (fmt),
        .have_byte (!q_empty),
        .next_byte (q_head),
        .bit_done  (bit_done),
        .take_byte (q_pop),
        .line      (ser_line),
        .busy      (ser_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            txd_q <= 1'b1;
        end else begin
            txd_q <= line_break ? 1'b0 : ser_line;
        end
    end

    assign txd        = txd_q;
    assign hold_empty = q_empty && !wr_en;
    assign tx_empty   = hold_empty && !ser_busy;

endmodule

// File: rtl/serial_tx_checker.sv
module serial_tx_checker #(
    parameter int DEPTH = 16,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          line_break,
    input logic          txd,
    input logic          hold_empty,
    input logic          tx_empty,
    input logic [LW-1:0] q_level,
    input logic          q_pop
);
    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(tx_empty) && !$past(line_break)) |-> txd);

    // R8
    break_forces_low_chk: assert property (@(posedge clk) disable iff (rst)
        line_break |=> !txd);

    // R9
    hold_flag_tracks_queue_chk: assert property (@(posedge clk) disable iff (rst)
        (q_level != '0) |-> !hold_empty);

    // R10
    loaded_not_empty_chk: assert property (@(posedge clk) disable iff (rst)
        q_pop |=> !tx_empty);

    // R11
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        q_level <= LW'(DEPTH));

    // R11
    full_write_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && q_level == LW'(DEPTH) && !q_pop) |=> (q_level == LW'(DEPTH)));

endmodule

bind serial_tx_top serial_tx_checker #(.DEPTH(QUEUE_DEPTH)) u_checker (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .line_break (line_break),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_empty   (tx_empty),
    .q_level    (q_level),
    .q_pop      (q_pop)
);

// File: tb/test_serial_tx_top.sv
module test_serial_tx_top;

    localparam int TICK_GAP = 4;
    localparam int BIT_CLKS = 16 * TICK_GAP;

    typedef struct {
        logic [7:0] data;
        int         nbits;
        bit         has_par;
        bit         par_val;
        int         nstop;
    } frame_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       baud_tick16 = 1'b0;
    logic [1:0] fmt_len = 2'd3;
    logic       fmt_stop2 = 1'b0;
    logic       fmt_par_en = 1'b0;
    logic       fmt_par_sel = 1'b0;
    logic       fmt_par_fix = 1'b0;
    logic       line_break = 1'b0;
    logic       txd;
    logic       hold_empty;
    logic       tx_empty;

    int     total = 0;
    int     bad = 0;
    frame_t expq[$];
    bit     mon_en = 1'b1;

    always #10 clk = ~clk;

    serial_tx_top i_serial_tx_top (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .baud_tick16 (baud_tick16),
        .fmt_len     (fmt_len),
        .fmt_stop2   (fmt_stop2),
        .fmt_par_en  (fmt_par_en),
        .fmt_par_sel (fmt_par_sel),
        .fmt_par_fix (fmt_par_fix),
        .line_break  (line_break),
        .txd         (txd),
        .hold_empty  (hold_empty),
        .tx_empty    (tx_empty)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // tick generator: one pulse every TICK_GAP clocks
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            cnt = (cnt == TICK_GAP - 1) ? 0 : cnt + 1;
            baud_tick16 = (cnt == 0);
        end
    end

    // driver: push a byte and its expected frame
    task automatic send(input logic [7:0] b, input bit expect_kept);
        frame_t f;
        logic [7:0] m;
        f.data    = b;
        f.nbits   = 5 + int'(fmt_len);
        m         = b & 8'((1 << f.nbits) - 1);
        f.has_par = fmt_par_en;
        if (fmt_par_fix) f.par_val = !fmt_par_sel;
        else if (fmt_par_sel) f.par_val = ^m;
        else f.par_val = ~^m;
        f.nstop   = fmt_stop2 ? 2 : 1;
        if (expect_kept) expq.push_back(f);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = b;
        #1;
        // R9: flag already low in the write cycle
        check(hold_empty == 1'b0, "R9", "hold_empty during write", hold_empty, 0);
    endtask

    task automatic end_write();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        int guard = 0;
        while (quiet < 20 && guard < 20000) begin
            @(negedge clk);
            guard++;
            quiet = tx_empty ? quiet + 1 : 0;
        end
    endtask

    // monitor: decode frames and compare against the scoreboard
    initial begin
        logic prev = 1'b1;
        forever begin
            @(negedge clk);
            if (mon_en && prev && !txd && !rst) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R11", "unexpected frame", 1, 0);
                    repeat (BIT_CLKS * 8) @(negedge clk);
                end else begin
                    frame_t f;
                    f = expq.pop_front();
                    repeat (BIT_CLKS / 2 - 1) @(negedge clk);
                    check(txd == 1'b0, "R2", "start bit", txd, 0);
                    for (int i = 0; i < f.nbits; i++) begin
                        repeat (BIT_CLKS) @(negedge clk);
                        check(txd == f.data[i], "R3", $sformatf("data bit %0d of %0h", i, f.data),
                              txd, f.data[i]);
                    end
                    if (f.has_par) begin
                        repeat (BIT_CLKS) @(negedge clk);
                        check(txd == f.par_val, "R6", "parity bit", txd, f.par_val);
                    end
                    for (int s = 0; s < f.nstop; s++) begin
                        repeat (BIT_CLKS) @(negedge clk);
                        check(txd == 1'b1, "R4", $sformatf("stop bit %0d", s), txd, 1);
                    end
                end
            end
            prev = txd;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1", "txd after reset", txd, 1);
        check(hold_empty == 1'b1, "R1", "hold_empty after reset", hold_empty, 1);
        check(tx_empty == 1'b1, "R1", "tx_empty after reset", tx_empty, 1);

        // R2 R3: 8 data bits, no parity, one stop
        send(8'h55, 1); end_write();
        repeat (100) @(negedge clk);
        // R10: queue drained, frame still running
        check(hold_empty == 1'b1, "R10", "hold_empty mid frame", hold_empty, 1);
        check(tx_empty == 1'b0, "R10", "tx_empty mid frame", tx_empty, 0);
        send(8'hA3, 1); send(8'h00, 1); send(8'hFF, 1); end_write();
        wait_idle();
        check(txd == 1'b1, "R1", "idle line after frames", txd, 1);

        // R3 R4: shorter words with two stop bits
        fmt_stop2 = 1'b1;
        for (int l = 0; l < 3; l++) begin
            fmt_len = 2'(l);
            send(8'hE6, 1); send(8'h19, 1); end_write();
            wait_idle();
        end

        // R6: odd and even parity
        fmt_len = 2'd3; fmt_stop2 = 1'b0; fmt_par_en = 1'b1; fmt_par_fix = 1'b0;
        fmt_par_sel = 1'b0;
        send(8'h03, 1); send(8'h07, 1); end_write();
        wait_idle();
        fmt_par_sel = 1'b1;
        send(8'h03, 1); send(8'h07, 1); end_write();
        wait_idle();
        fmt_len = 2'd1;
        send(8'hC1, 1); end_write();
        wait_idle();

        // R7: forced mark and forced space
        fmt_len = 2'd3; fmt_par_fix = 1'b1; fmt_par_sel = 1'b0;
        send(8'h01, 1); end_write();
        wait_idle();
        fmt_par_sel = 1'b1;
        send(8'hFE, 1); end_write();
        wait_idle();

        // R5: parity disabled while the fixed-space setting is present
        fmt_par_en = 1'b0;
        send(8'h81, 1); send(8'h42, 1); end_write();
        wait_idle();
        fmt_par_fix = 1'b0; fmt_par_sel = 1'b0;

        // R8: break holds the line low until cleared
        mon_en = 1'b0;
        @(negedge clk);
        line_break = 1'b1;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            check(txd == 1'b0, "R8", "txd under break", txd, 0);
            repeat (150) @(negedge clk);
        end
        check(hold_empty == 1'b1, "R8", "hold_empty under break", hold_empty, 1);
        check(tx_empty == 1'b1, "R8", "tx_empty under break", tx_empty, 1);
        line_break = 1'b0;
        repeat (2) @(negedge clk);
        check(txd == 1'b1, "R8", "txd after break cleared", txd, 1);
        repeat (4) @(negedge clk);
        mon_en = 1'b1;

        // R11: eighteen back-to-back writes, the last meets a full queue
        for (int n = 0; n < 18; n++) begin
            send(8'(8'h20 + n), n < 17);
        end
        end_write();
        check(hold_empty == 1'b0, "R11", "hold_empty with full queue", hold_empty, 0);
        wait_idle();
        repeat (BIT_CLKS * 12) @(negedge clk);
        check(expq.size() == 0, "R11", "frames still expected", expq.size(), 0);
        check(txd == 1'b1, "R1", "idle line at end", txd, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule